// File: doc/BRIEF.md
# Burst pi/4-Shift DQPSK Symbol Mapper

This block turns a serial transmit bit stream into a sequence of carrier phase codes for pi/4-shift differential QPSK. Inside a burst window it pairs the incoming bits into dibits. For each dibit it advances a 3-bit phase index, counted in 45-degree steps, by an odd number of steps. It also produces an amplitude code that ramps up at the start of a burst and down at the end, plus a copy of the burst window delayed to line up with the modulated output. A later pulse-shaping and conversion stage consumes the phase and amplitude codes.

Bit timing comes from a transmit clock input in one of two modes, chosen by `clk_mode`. In mode 0 that input is the bit clock itself. In mode 1 it is ten times faster and is divided down inside the block. All inputs are sampled on the system clock `clk`. The integrator supplies `os_tick`, a one-cycle strobe at eight per symbol, which paces the output codes, the ramps and the window delay.

Top module: `pi4_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `phase_o`, `amp_o`, `win_out` and `txc_out` are all 0.
- R2: With `clk_mode`=0, one bit of `txd` is taken on each rising edge of `txc_in`, and `txc_out` follows `txc_in` one clock later.
- R3: With `clk_mode`=1, `txc_out` is `txc_in` divided by ten. Counting rising edges of `txc_in` from reset, `txc_out` is high after edges 5 to 9 of each group of ten and low after edges 10 to 14, and one bit of `txd` is taken only on the edge where `txc_out` rises.
- R4: A dibit is {first bit taken, second bit taken}. Dibit 00 adds 1 to the phase index, 01 adds 3, 11 adds 5 and 10 adds 7, all modulo 8.
- R5: Bits arriving while `win_in` is low are dropped. Bit pairing restarts with the first bit taken after `win_in` rises.
- R6: On each `os_tick`, `amp_o` rises by 1 while `win_in` is high, up to a ceiling of 16 (two symbols of ticks). While `win_in` is low it falls by 1 per tick, down to 0.
- R7: After each `os_tick`, `win_out` equals the value `win_in` had at the `os_tick` 49 ticks earlier, which puts it 50 ticks (6.25 symbols) behind the input.
- R8: While `mod_off` is high, completed dibits leave the phase index unchanged.
- R9: Once `win_in` is low and `amp_o` is 0, the phase index returns to 0, and the next `os_tick` presents 0 on `phase_o`.
- R10: `phase_o` and `amp_o` change only on a cycle with `os_tick` high. At that tick `phase_o` takes the phase index as it stood before any dibit that completes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| txc_in | input | 1 | Transmit clock input, sampled on `clk` |
| clk_mode | input | 1 | 0: `txc_in` is the bit clock; 1: `txc_in` runs at ten times the bit rate |
| txd | input | 1 | Serial transmit data |
| win_in | input | 1 | Burst window input |
| mod_off | input | 1 | Freezes the phase index when high |
| os_tick | input | 1 | Output sample strobe, eight per symbol |
| txc_out | output | 1 | Bit clock output (divided clock in mode 1) |
| win_out | output | 1 | Burst window delayed by 50 ticks |
| phase_o | output | 3 | Phase index in 45-degree steps |
| amp_o | output | 5 | Ramp amplitude code, 0 to 16 |

## Verification
The two functions that can fall in one cycle are completion of a dibit and the output sample tick. They interact because the tick copies the phase index just as the index is being advanced. The bench provokes this by raising the second bit's clock edge and `os_tick` on the same cycle. It expects the tick to present the old phase and the following tick to present the new one. A second overlap, the end of the ramp-down coinciding with the phase clearing, is checked by confirming that the last ramp tick still shows the held phase and that 0 appears only on the next tick.

// File: rtl/pi4_mapper_pkg.sv
package pi4_mapper_pkg;
  localparam int PH_W = 3;
  typedef logic [PH_W-1:0] phase_t;

  // Gray-coded dibit to phase step in 45-degree units
  function automatic phase_t dibit_step(input logic [1:0] d);
    case (d)
      2'b00:   return phase_t'(1);
      2'b01:   return phase_t'(3);
      2'b11:   return phase_t'(5);
      default: return phase_t'(7);
    endcase
  endfunction
endpackage

// File: rtl/pi4_txclk.sv
module pi4_txclk #(
  parameter int DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic txc_in,
  input  logic clk_mode,
  output logic bit_stb,
  output logic txc_out
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;

  logic          txc_q;
  logic          div_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic          rise;

  assign rise    = txc_in & ~txc_q;
  assign cnt_nxt = (cnt == CW'(DIV - 1)) ? '0 : cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      txc_q <= 1'b0;
      div_q <= 1'b0;
      cnt   <= '0;
    end else begin
      txc_q <= txc_in;
      if (rise) begin
        cnt   <= cnt_nxt;
        div_q <= (cnt_nxt >= CW'(HALF));
      end
    end
  end

  assign bit_stb = clk_mode ? (rise && (cnt == CW'(HALF - 1))) : rise;
  assign txc_out = clk_mode ? div_q : txc_q;

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(div_q));
  // R3
  div_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_mode && $past(clk_mode) && $rose(div_q)) |-> $past(bit_stb));
endmodule

// File: rtl/pi4_dibit_phase.sv
module pi4_dibit_phase
  import pi4_mapper_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_stb,
  input  logic   txd,
  input  logic   win_in,
  input  logic   mod_off,
  input  logic   clear,
  output phase_t phase_acc
);
  logic half;
  logic first_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      half      <= 1'b0;
      first_b   <= 1'b0;
      phase_acc <= '0;
    end else if (!win_in) begin
      half <= 1'b0;
      if (clear) phase_acc <= '0;
    end else if (bit_stb) begin
      if (!half) begin
        first_b <= txd;
        half    <= 1'b1;
      end else begin
        half <= 1'b0;
        if (!mod_off) phase_acc <= phase_acc + dibit_step({first_b, txd});
      end
    end
  end

  // R8
  modoff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (win_in && mod_off) |=> $stable(phase_acc));
  // R5
  nowin_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_in && !clear) |=> $stable(phase_acc));
  // R4
  odd_step_chk: assert property (@(posedge clk) disable iff (rst)
    (win_in && bit_stb && half && !mod_off) |=> (phase_acc[0] != $past(phase_acc[0])));
endmodule

// File: rtl/pi4_burst_shaper.sv
module pi4_burst_shaper
  import pi4_mapper_pkg::*;
#(
  parameter int SPS      = 8,
  parameter int RAMP_SYM = 2,
  parameter int DLY      = 50,
  localparam int RAMP_LEN = SPS * RAMP_SYM,
  localparam int AW       = $clog2(RAMP_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          os_tick,
  input  logic          win_in,
  input  phase_t        phase_in,
  output logic [AW-1:0] amp_o,
  output phase_t        phase_o,
  output logic          win_out,
  output logic          amp_zero
);
  logic [AW-1:0]  amp_q;
  phase_t         phase_q;
  logic [DLY-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_q   <= '0;
      phase_q <= '0;
      sr      <= '0;
    end else if (os_tick) begin
      phase_q <= phase_in;
      sr      <= {sr[DLY-2:0], win_in};
      if (win_in && (amp_q != AW'(RAMP_LEN))) amp_q <= amp_q + AW'(1);
      else if (!win_in && (amp_q != '0))      amp_q <= amp_q - AW'(1);
    end
  end

  assign amp_o    = amp_q;
  assign phase_o  = phase_q;
  assign win_out  = sr[DLY-1];
  assign amp_zero = (amp_q == '0);

  // R10
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    !os_tick |=> ($stable(amp_q) && $stable(phase_q) && $stable(sr)));
  // R6
  amp_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    amp_q <= AW'(RAMP_LEN));
  // R6
  amp_unit_step_chk: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> ((amp_q == $past(amp_q)) || (amp_q == $past(amp_q) + AW'(1))
                 || ($past(amp_q) == amp_q + AW'(1))));
endmodule

// File: rtl/pi4_mapper.sv
module pi4_mapper
  import pi4_mapper_pkg::*;
#(
  parameter int DIV      = 10,
  parameter int SPS      = 8,
  parameter int RAMP_SYM = 2,
  parameter int DLY      = 50,
  localparam int AW      = $clog2(SPS * RAMP_SYM + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          txc_in,
  input  logic          clk_mode,
  input  logic          txd,
  input  logic          win_in,
  input  logic          mod_off,
  input  logic          os_tick,
  output logic          txc_out,
  output logic          win_out,
  output logic [2:0]    phase_o,
  output logic [AW-1:0] amp_o
);
  logic   bit_stb;
  logic   amp_zero;
  phase_t phase_acc;

  pi4_txclk #(.DIV(DIV)) clk_i (
    .clk(clk), .rst(rst), .txc_in(txc_in), .clk_mode(clk_mode),
    .bit_stb(bit_stb), .txc_out(txc_out)
  );

  pi4_dibit_phase map_i (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .txd(txd), .win_in(win_in),
    .mod_off(mod_off), .clear(amp_zero), .phase_acc(phase_acc)
  );

  pi4_burst_shaper #(.SPS(SPS), .RAMP_SYM(RAMP_SYM), .DLY(DLY)) shp_i (
    .clk(clk), .rst(rst), .os_tick(os_tick), .win_in(win_in),
    .phase_in(phase_acc), .amp_o(amp_o), .phase_o(phase_o),
    .win_out(win_out), .amp_zero(amp_zero)
  );

  // R9
  idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_in && amp_zero && !$past(win_in) && $past(amp_zero)) |-> (phase_acc == '0));
endmodule

// File: tb/pi4_mapper_tb.sv
module pi4_mapper_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, txc_in = 1'b0, clk_mode = 1'b0, txd = 1'b0;
  logic win_in = 1'b0, mod_off = 1'b0, os_tick = 1'b0;
  logic txc_out, win_out;
  logic [2:0] phase_o;
  logic [4:0] amp_o;

  pi4_mapper dut_i (
    .clk(clk), .rst(rst), .txc_in(txc_in), .clk_mode(clk_mode), .txd(txd),
    .win_in(win_in), .mod_off(mod_off), .os_tick(os_tick),
    .txc_out(txc_out), .win_out(win_out), .phase_o(phase_o), .amp_o(amp_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // requirement-derived model
  int m_acc, m_amp, m_pho, m_edges;
  bit m_half, m_first;
  bit hist[50];

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int step(bit a, bit b);
    case ({a, b})
      2'b00: return 1;
      2'b01: return 3;
      2'b11: return 5;
      default: return 7;
    endcase
  endfunction

  task automatic model_bit(bit b);
    if (!win_in) return;
    if (!m_half) begin m_first = b; m_half = 1'b1; end
    else begin
      m_half = 1'b0;
      if (!mod_off) m_acc = (m_acc + step(m_first, b)) % 8;
    end
  endtask

  task automatic model_tick();
    m_pho = m_acc;
    if (win_in && m_amp < 16) m_amp++;
    else if (!win_in && m_amp > 0) m_amp--;
    for (int i = 49; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = win_in;
    if (!win_in && m_amp == 0) m_acc = 0;
  endtask

  task automatic check_outs(string req);
    chk(req, "phase_o", phase_o, m_pho);
    chk(req, "amp_o", amp_o, m_amp);
    chk(req, "win_out", win_out, hist[49]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; txc_in = 0; clk_mode = 0; txd = 0; win_in = 0; mod_off = 0; os_tick = 0;
    repeat (3) @(negedge clk);
    chk("R1", "phase_o in reset", phase_o, 0);
    rst = 1'b0;
    m_acc = 0; m_amp = 0; m_pho = 0; m_edges = 0; m_half = 0; m_first = 0;
    for (int i = 0; i < 50; i++) hist[i] = 0;
  endtask

  task automatic set_win(bit v);
    @(negedge clk);
    win_in = v;
    if (!v) begin
      m_half = 1'b0;
      if (m_amp == 0) m_acc = 0;
    end
  endtask

  task automatic bit0(bit b);
    @(negedge clk);
    txd = b; txc_in = 1'b1;
    model_bit(b);
    @(negedge clk);
    txc_in = 1'b0;
  endtask

  task automatic tick(string req);
    @(negedge clk);
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
    model_tick();
    check_outs(req);
  endtask

  task automatic dibit(bit a, bit b);
    bit0(a);
    bit0(b);
  endtask

  task automatic edge1(bit b);
    @(negedge clk);
    txd = b; txc_in = 1'b1;
    m_edges++;
    if (m_edges % 10 == 5) model_bit(b);
    @(negedge clk);
    txc_in = 1'b0;
    chk("R3", "txc_out level", txc_out, ((m_edges % 10) >= 5) ? 1 : 0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", "phase_o", phase_o, 0);
    chk("R1", "amp_o", amp_o, 0);
    chk("R1", "win_out", win_out, 0);
    chk("R1", "txc_out", txc_out, 0);
  endtask

  task automatic t_mapping();
    do_reset();
    set_win(1);
    @(negedge clk); txc_in = 1'b1; txd = 1'b0; model_bit(0);
    @(negedge clk);
    chk("R2", "txc_out follows txc_in", txc_out, 1);
    txc_in = 1'b0;
    bit0(0);                          // dibit 00
    chk("R10", "phase_o before tick", phase_o, 0);
    tick("R4");
    chk("R4", "00 gives 1", phase_o, 1);
    dibit(0, 1); tick("R4"); chk("R4", "01 adds 3", phase_o, 4);
    dibit(1, 1); tick("R4"); chk("R4", "11 adds 5", phase_o, 1);
    dibit(1, 0); tick("R4"); chk("R4", "10 adds 7", phase_o, 0);
    dibit(1, 1); dibit(1, 1); tick("R4"); chk("R4", "wrap modulo 8", phase_o, 2);
    for (int i = 0; i < 14; i++) tick("R6");
    chk("R6", "ramp ceiling", amp_o, 16);
  endtask

  task automatic t_ramp_down();
    set_win(0);
    for (int i = 0; i < 15; i++) tick("R6");
    chk("R6", "one step above zero", amp_o, 1);
    tick("R9");
    chk("R9", "last ramp tick keeps phase", phase_o, 2);
    chk("R6", "ramp reaches zero", amp_o, 0);
    tick("R9");
    chk("R9", "phase cleared after burst", phase_o, 0);
  endtask

  task automatic t_window_delay();
    do_reset();
    set_win(1);
    for (int i = 0; i < 49; i++) tick("R7");
    chk("R7", "win_out still low at tick 49", win_out, 0);
    tick("R7");
    chk("R7", "win_out high at tick 50", win_out, 1);
    set_win(0);
    for (int i = 0; i < 49; i++) tick("R7");
    chk("R7", "win_out still high", win_out, 1);
    tick("R7");
    chk("R7", "win_out low", win_out, 0);
  endtask

  task automatic t_ignore();
    do_reset();
    dibit(1, 1);
    tick("R5");
    chk("R5", "bits outside window dropped", phase_o, 0);
    set_win(1);
    bit0(1);
    set_win(0);
    set_win(1);
    dibit(0, 0);
    tick("R5");
    chk("R5", "pairing restarts", phase_o, 1);
  endtask

  task automatic t_modoff();
    do_reset();
    set_win(1);
    dibit(0, 1);
    tick("R8");
    @(negedge clk); mod_off = 1'b1;
    dibit(0, 1); dibit(1, 1);
    tick("R8");
    chk("R8", "phase frozen", phase_o, 3);
    @(negedge clk); mod_off = 1'b0;
    dibit(0, 0);
    tick("R8");
    chk("R8", "stepping resumes", phase_o, 4);
  endtask

  task automatic t_mode1();
    do_reset();
    @(negedge clk); clk_mode = 1'b1;
    set_win(1);
    for (int e = 1; e <= 20; e++) edge1((e == 15) ? 1'b1 : ((e % 10 == 5) ? 1'b0 : 1'b1));
    tick("R3");
    chk("R3", "divided clock bits 0,1", phase_o, 3);
  endtask

  task automatic t_coincide();
    do_reset();
    set_win(1);
    bit0(1);
    @(negedge clk);
    txd = 1'b1; txc_in = 1'b1; os_tick = 1'b1;
    model_tick();
    model_bit(1);
    @(negedge clk);
    txc_in = 1'b0; os_tick = 1'b0;
    check_outs("R10");
    chk("R10", "tick shows pre-dibit phase", phase_o, 0);
    tick("R10");
    chk("R10", "next tick shows new phase", phase_o, 5);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    t_reset();
    t_mapping();
    t_ramp_down();
    t_window_delay();
    t_ignore();
    t_modoff();
    t_mode1();
    t_coincide();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule